// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is the bus-side half of a small 8-bit processor whose external bus shares one byte-wide lane between the low address byte and data. When the core asks for a machine cycle, the sequencer steps through a fixed run of T-states. Each T-state lasts one clock. The kinds of cycle are an opcode fetch, a memory read, a memory write, an I/O read and an I/O write. Across those T-states it drives the upper address byte, puts the lower address byte on the shared lane with an address-latch strobe, and shows the cycle kind on a memory/IO select and two status lines. It pulses the active-low read or write strobe, and it either samples the shared lane or drives write data onto it.

The shared lane is exposed as three separate signals: an output byte, an output enable and an input byte. The pad-level tri-state buffer is placed outside the block. For an opcode fetch, the core supplies the program counter on the request address. When the cycle ends, the block raises a one-clock done pulse, returns to idle and presents the byte it captured.

Top module: `mux_bus_seq`

## Requirements
- R1: A request is taken only when `ready` is high (idle) and `req_kind` is a legal code: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 are ignored, and the block stays idle. `ready` is low from T1 until the cycle ends.
- R2: T1 is the first clock after acceptance. In T1, `addr_hi` carries address bits 15:8, `ad_out` carries bits 7:0 with `ad_oe` high, and `ale` is high.
- R3: During every T-state of a cycle, `io_m` is 0 for memory kinds and 1 for I/O kinds. `{s1,s0}` is 11 for an opcode fetch, 10 for a read and 01 for a write. Both fields hold steady for the whole cycle.
- R4: `ale` is low in T2 and in every later T-state.
- R5: For an opcode fetch or a read, `rd_n` is low in T2 and T3, and `ad_oe` is low in both of them.
- R6: For a write, `wr_n` is low in T2 and T3, and `ad_out` carries the request write data with `ad_oe` high in both of them.
- R7: For an opcode fetch or a read, the value of `ad_in` at the clock edge that ends T3 becomes `rdata`. `rdata` keeps that value until the next read-type cycle captures a new one.
- R8: An opcode fetch adds a T4 after T3. In T4 both strobes are high, `ale` is low, `ad_oe` is low, and status and `addr_hi` are held. Every other kind ends after T3.
- R9: `done` is high for exactly one clock, the clock after the final T-state, and `ready` is high in that same clock.
- R10: While idle, `rd_n` and `wr_n` are high, `ale` and `ad_oe` are low, `ad_out` is 0, `io_m` is 0, `{s1,s0}` is 00, and `addr_hi` keeps its last value. `ad_out` is 0 whenever `ad_oe` is low. A request held during a busy cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address (program counter for fetch) |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | High when idle and able to take a request |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Last captured read byte |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared lane output value |
| ad_oe | output | 1 | Shared lane output enable |
| ad_in | input | 8 | Shared lane input value |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | 0 memory, 1 I/O |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
From the ports, the hardest case to reach is a request that is held while the block is busy. It must leave the running cycle untouched and must not slip in at the edge where T3 or T4 hands over to idle. The stimulus keeps `req_valid` high with random legal kinds and addresses through random cycles, and drops it only in the done clock. Every T-state is compared against the expected pins, and the idle clock that follows is checked too. Directed cases add illegal kind codes, the extreme addresses, and a read-back of `rdata` after a write to show that writes do not disturb it.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } tstate_e;

  typedef enum logic [2:0] {
    CK_FETCH = 3'd0,
    CK_MRD   = 3'd1,
    CK_MWR   = 3'd2,
    CK_IORD  = 3'd3,
    CK_IOWR  = 3'd4
  } ckind_e;

  localparam logic [2:0] KIND_MAX = 3'd4;

  function automatic logic kind_reads(ckind_e k);
    return (k == CK_FETCH) || (k == CK_MRD) || (k == CK_IORD);
  endfunction

  function automatic logic kind_writes(ckind_e k);
    return (k == CK_MWR) || (k == CK_IOWR);
  endfunction

  function automatic logic kind_io(ckind_e k);
    return (k == CK_IORD) || (k == CK_IOWR);
  endfunction

  function automatic logic [1:0] kind_status(ckind_e k);
    logic [1:0] st;
    if (k == CK_FETCH)      st = 2'b11;
    else if (kind_reads(k)) st = 2'b10;
    else                    st = 2'b01;
    return st;
  endfunction
endpackage

// File: rtl/mbs_tseq.sv
module mbs_tseq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output tstate_e           state_q,
  output tstate_e           state_d,
  output ckind_e            kind_q,
  output ckind_e            kind_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] wdata_d,
  output logic              idle
);
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && req_valid && (req_kind <= KIND_MAX);

  assign kind_d  = accept ? ckind_e'(req_kind) : kind_q;
  assign addr_d  = accept ? req_addr : addr_q;
  assign wdata_d = accept ? req_wdata : wdata_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = (kind_q == CK_FETCH) ? ST_T4 : ST_IDLE;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= CK_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  // A bus cycle only starts from idle
  p_start_from_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_T1) |-> $past(state_q == ST_IDLE));

  // Request fields are frozen while busy
  p_kind_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && $past(state_q != ST_IDLE)) |-> $stable(kind_q));
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tstate_e                  state_q,
  input  tstate_e                  state_d,
  input  ckind_e                   kind_q,
  input  ckind_e                   kind_d,
  input  logic [ADDR_W-1:0]        addr_d,
  input  logic [DATA_W-1:0]        wdata_d,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n
);
  logic strobe_win;
  logic nxt_busy;
  logic wr_drive;

  assign nxt_busy   = (state_d != ST_IDLE);
  assign strobe_win = (state_d == ST_T2) || (state_d == ST_T3);
  assign wr_drive   = strobe_win && kind_writes(kind_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      rdata   <= '0;
      addr_hi <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      ale     <= 1'b0;
      io_m    <= 1'b0;
      {s1, s0} <= 2'b00;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
    end else begin
      ale   <= (state_d == ST_T1);
      rd_n  <= !(strobe_win && kind_reads(kind_d));
      wr_n  <= !wr_drive;
      ad_oe <= (state_d == ST_T1) || wr_drive;
      if (state_d == ST_T1)  ad_out <= addr_d[DATA_W-1:0];
      else if (wr_drive)     ad_out <= wdata_d;
      else                   ad_out <= '0;
      if (nxt_busy) begin
        addr_hi  <= addr_d[ADDR_W-1:DATA_W];
        io_m     <= kind_io(kind_d);
        {s1, s0} <= kind_status(kind_d);
      end else begin
        io_m     <= 1'b0;
        {s1, s0} <= 2'b00;
      end
      if (state_q == ST_T3 && kind_reads(kind_q)) rdata <= ad_in;
      done <= (state_q == ST_T4) || (state_q == ST_T3 && kind_q != CK_FETCH);
    end
  end

  p_strobes_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_read_released_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  p_ale_single_r4: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (rd_n && wr_n && !ale && !ad_oe));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n
);
  tstate_e           state_q, state_d;
  ckind_e            kind_q, kind_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;

  mbs_tseq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tseq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .state_q(state_q),
    .state_d(state_d), .kind_q(kind_q), .kind_d(kind_d), .addr_d(addr_d),
    .wdata_d(wdata_d), .idle(ready)
  );

  mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .kind_q(kind_q), .kind_d(kind_d), .addr_d(addr_d), .wdata_d(wdata_d),
    .ad_in(ad_in), .done(done), .rdata(rdata), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .io_m(io_m), .s1(s1),
    .s0(s0), .rd_n(rd_n), .wr_n(wr_n)
  );

  // Status held through the cycle once it has begun
  p_status_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready)) |-> $stable({io_m, s1, s0}));

  // Address strobe only follows an idle clock
  p_ale_after_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> $past(ready));
endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] ad_in = '0;
  logic ready, done, ad_oe, ale, io_m, s1, s0, rd_n, wr_n;
  logic [7:0] rdata, addr_hi, ad_out;

  int n_checks = 0;
  int n_fails = 0;
  logic [7:0]  exp_rdata = '0;
  logic [15:0] last_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rdata(rdata), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n),
    .wr_n(wr_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] observed();
    return {9'd0, addr_hi, ad_out, ad_oe, ale, io_m, s1, s0, rd_n, wr_n};
  endfunction

  // ph: 0 idle, 1..4 T-state
  function automatic logic [31:0] expect_pins(input logic [2:0] k, input int ph,
                                              input logic [15:0] a, input logic [7:0] wd);
    logic rd, wr, io, oe;
    logic [1:0] st;
    logic [7:0] ado;
    rd = (k == 0 || k == 1 || k == 3) && (ph == 2 || ph == 3);
    wr = (k == 2 || k == 4) && (ph == 2 || ph == 3);
    io = (k == 3 || k == 4) && ph != 0;
    st = (ph == 0) ? 2'b00 : (k == 0) ? 2'b11 : (k == 1 || k == 3) ? 2'b10 : 2'b01;
    oe = (ph == 1) || wr;
    ado = (ph == 1) ? a[7:0] : wr ? wd : 8'h00;
    return {9'd0, a[15:8], ado, oe, (ph == 1), io, st, !rd, !wr};
  endfunction

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] din, input bit junk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (junk) begin
      req_kind = 3'($urandom % 5); req_addr = 16'($urandom); req_wdata = 8'($urandom);
    end else req_valid = 1'b0;
    check("R1 busy not ready", {31'd0, ready}, 32'd0);
    check("R2 R3 T1 pins", observed(), expect_pins(k, 1, a, wd));
    @(negedge clk);
    check("R4 R5 R6 T2 pins", observed(), expect_pins(k, 2, a, wd));
    ad_in = din;
    @(negedge clk);
    check("R5 R6 R3 T3 pins", observed(), expect_pins(k, 3, a, wd));
    if (k == 0) begin
      @(negedge clk);
      ad_in = ~din;
      check("R8 T4 pins", observed(), expect_pins(k, 4, a, wd));
      check("R8 no done in T4", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    ad_in = 8'($urandom);
    if (k == 0 || k == 1 || k == 3) exp_rdata = din;
    last_addr = a;
    check("R9 done pulse", {30'd0, done, ready}, 32'd3);
    check("R7 rdata", {24'd0, rdata}, {24'd0, exp_rdata});
    check("R10 idle after cycle pins", observed(), expect_pins(k, 0, a, wd));
    @(negedge clk);
    check("R9 done one clock", {31'd0, done}, 32'd0);
    check("R10 idle pins", observed(), expect_pins(k, 0, a, wd));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset pins", observed(), expect_pins(3'd0, 0, 16'h0000, 8'h00));
    check("R9 reset done/ready", {30'd0, done, ready}, 32'd1);
    check("R7 reset rdata", {24'd0, rdata}, 32'd0);

    // illegal kinds ignored
    for (int c = 5; c < 8; c++) begin
      req_valid = 1'b1; req_kind = 3'(c); req_addr = 16'hA5A5;
      @(negedge clk);
      check("R1 illegal kind ignored", {31'd0, ready}, 32'd1);
      check("R1 illegal kind pins", observed(), expect_pins(3'd0, 0, last_addr, 8'h00));
    end
    req_valid = 1'b0;
    @(negedge clk);

    // directed corners
    run_cycle(3'd0, 16'hFFFF, 8'h00, 8'h4F, 1'b0);
    run_cycle(3'd2, 16'h0000, 8'hFF, 8'h11, 1'b0);
    check("R7 rdata kept after write", {24'd0, rdata}, 32'h4F);
    run_cycle(3'd3, 16'h00FE, 8'h00, 8'h80, 1'b1);
    run_cycle(3'd4, 16'h1234, 8'hC3, 8'h00, 1'b1);
    run_cycle(3'd1, 16'h2005, 8'h00, 8'h3C, 1'b0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      run_cycle(3'($urandom % 5), 16'($urandom), 8'($urandom), 8'($urandom),
                1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule